// File: doc/BRIEF.md
# Key-Guarded System Configuration Registers

This block is a small register file on a 32-bit register bus that holds the settings for a chip's system controller. Two of its registers, a device-configuration word and an audio clock-divider word, are guarded. A guarded register accepts a write only when the bus write right before it stored the unlock key 0xAA in the key register. Software therefore writes the key and then immediately writes the new value. Changing only some bits takes a read, a modify in software, the key write and the data write.

A third register is read-only and reports a chip revision number in a fixed bit field. A write to a guarded register while the guard is shut is dropped and sets a sticky error bit that software can read and clear. The top bit of the device-configuration word is a software-reset request. A protected write that takes this bit from 1 to 0 produces a reset pulse of fixed length on a dedicated output. The bus is a plain single-cycle register interface with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` and is qualified by `bus_sel` with `bus_wr` low.

Top module: `sc_guarded_cfg`

## Requirements
- R1: After reset the device-configuration word equals `DEVCFG_RST` (default 0), the clock-divider word is 0, the guard is shut, the error bit is 0 and `srst_o` is low.
- R2: A write of exactly 32'h000000AA to word offset 0 opens the guard. A read of offset 0 returns 1 while the guard is open and 0 while it is shut.
- R3: A write to offset 1 (device configuration) or offset 2 (clock divider) made while the guard is open stores the full 32-bit write data.
- R4: Every bus write shuts the guard at its edge, except a key write of 0xAA. This covers writes to guarded registers, whether they succeed or not, and key writes of any other value.
- R5: A write to offset 1 or 2 made while the guard is shut leaves that register unchanged.
- R6: A refused guarded write sets bit 0 of the status word at offset 4. The bit stays set until any write to offset 4, which clears it.
- R7: Offset 3 reads `REV_VALUE` (default 4'h5) in bits [31:28] and 0 elsewhere. Writes to offset 3 change nothing it returns.
- R8: A successful write to offset 1 that moves bit 31 from 1 to 0 drives `srst_o` high for exactly `PULSE_CYC` (default 4) cycles, starting the cycle after the write edge. Setting bit 31, or writing 0 to a bit 31 that is already 0, produces no pulse.
- R9: Reads do not change the guard, so a read placed between the key write and the guarded write does not close the guard.
- R10: Offsets 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| srst_o | output | 1 | Software reset pulse |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` change only away from the rising edge. They also assume no second 1-to-0 reset request arrives while a pulse is still running. Only then does the pulse-length check reduce to a simple bound. The stimulus drives every bus field on the falling edge. It spaces its reset requests through key writes, which keeps any two 1-to-0 clears at least `PULSE_CYC` cycles apart. The sweeps exercise every offset as the write that comes between the key and the guarded access.

// File: rtl/sc_cfg_pkg.sv
package sc_cfg_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    OFS_KEY  = 3'd0,
    OFS_DEV  = 3'd1,
    OFS_CLK  = 3'd2,
    OFS_ID   = 3'd3,
    OFS_STAT = 3'd4
  } sc_ofs_e;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_00AA;
  localparam int NPROT = 2;

  function automatic logic ofs_is_guarded(input logic [AW-1:0] a);
    return (a == OFS_DEV) || (a == OFS_CLK);
  endfunction
endpackage

// File: rtl/sc_key_guard.sv
module sc_key_guard
  import sc_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          guard_open,
  output logic          err_flag,
  output logic          commit
);
  logic key_hit;
  logic guarded;
  logic refused;

  always_comb begin
    key_hit = wr_en && (wr_addr == OFS_KEY) && (wr_data == UNLOCK_KEY);
    guarded = wr_en && ofs_is_guarded(wr_addr);
    commit  = guarded && guard_open;
    refused = guarded && !guard_open;
  end

  // any write re-arms or shuts the guard; reads leave it alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_open <= 1'b0;
    end else if (wr_en) begin
      guard_open <= key_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
    end else if (refused) begin
      err_flag <= 1'b1;
    end else if (wr_en && (wr_addr == OFS_STAT)) begin
      err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_lock_regs.sv
module sc_lock_regs
  import sc_cfg_pkg::*;
#(
  parameter int N = NPROT,
  parameter logic [N*DW-1:0] RST_VALS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  logic [DW-1:0]   wdata,
  output logic [N*DW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i*DW +: DW] <= RST_VALS[i*DW +: DW];
      end else if (we[i]) begin
        q[i*DW +: DW] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sc_reset_pulser.sv
module sc_reset_pulser #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (trig) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/sc_guarded_cfg.sv
module sc_guarded_cfg
  import sc_cfg_pkg::*;
#(
  parameter logic [DW-1:0] DEVCFG_RST = '0,
  parameter int            SWRST_BIT  = 31,
  parameter int            REV_LSB    = 28,
  parameter int            REV_W      = 4,
  parameter logic [REV_W-1:0] REV_VALUE = 4'h5,
  parameter int            PULSE_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          srst_o
);
  localparam int IDX_DEV = 0;
  localparam int IDX_CLK = 1;
  localparam logic [NPROT*DW-1:0] RSTS = {{DW{1'b0}}, DEVCFG_RST};

  logic              wr_en;
  logic              guard_open;
  logic              err_flag;
  logic              commit;
  logic [NPROT-1:0]  we;
  logic [NPROT*DW-1:0] prot_q;
  logic [DW-1:0]     dev_q;
  logic [DW-1:0]     clk_q;
  logic [DW-1:0]     id_word;
  logic              rst_trig;

  assign wr_en = bus_sel && bus_wr;

  sc_key_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .guard_open (guard_open),
    .err_flag   (err_flag),
    .commit     (commit)
  );

  always_comb begin
    we          = '0;
    we[IDX_DEV] = commit && (bus_addr == OFS_DEV);
    we[IDX_CLK] = commit && (bus_addr == OFS_CLK);
  end

  sc_lock_regs #(.N(NPROT), .RST_VALS(RSTS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .wdata (bus_wdata),
    .q     (prot_q)
  );

  assign dev_q = prot_q[IDX_DEV*DW +: DW];
  assign clk_q = prot_q[IDX_CLK*DW +: DW];

  // request fires on an accepted 1 -> 0 transition of the reset bit
  assign rst_trig = we[IDX_DEV] && dev_q[SWRST_BIT] && !bus_wdata[SWRST_BIT];

  sc_reset_pulser #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (rst_trig),
    .pulse (srst_o)
  );

  always_comb begin
    id_word = '0;
    id_word[REV_LSB +: REV_W] = REV_VALUE;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_KEY:  bus_rdata = {{(DW-1){1'b0}}, guard_open};
      OFS_DEV:  bus_rdata = dev_q;
      OFS_CLK:  bus_rdata = clk_q;
      OFS_ID:   bus_rdata = id_word;
      OFS_STAT: bus_rdata = {{(DW-1){1'b0}}, err_flag};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sc_guarded_cfg_chk.sv
module sc_guarded_cfg_chk #(
  parameter int PULSE_CYC = 4,
  parameter int SWRST_BIT = 31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        guard_open,
  input logic        err_flag,
  input logic [31:0] dev_q,
  input logic [31:0] clk_q,
  input logic        srst_o
);
  localparam int HW = $clog2(PULSE_CYC + 1) + 1;
  logic [HW-1:0] hi_run;
  logic          wr_en;
  logic          prot_wr;

  assign wr_en   = bus_sel && bus_wr;
  assign prot_wr = wr_en && ((bus_addr == 3'd1) || (bus_addr == 3'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (srst_o) hi_run <= hi_run + 1'b1;
    else             hi_run <= '0;
  end

  AST_KEY_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd0) |-> (bus_rdata == {31'b0, guard_open})); // R2

  AST_GUARD_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(bus_addr == 3'd0 && bus_wdata == 32'hAA)) |=> !guard_open); // R4

  AST_LOCKED_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 3'd1 && !guard_open) |=> $stable(dev_q)); // R5

  AST_LOCKED_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 3'd2 && !guard_open) |=> $stable(clk_q)); // R5

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !guard_open) |=> err_flag); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(wr_en && bus_addr == 3'd4)) |=> err_flag); // R6

  AST_READ_KEEPS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(guard_open)); // R9

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 3'd1 && guard_open && dev_q[SWRST_BIT] && !bus_wdata[SWRST_BIT])
    |=> srst_o); // R8

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> (hi_run < HW'(PULSE_CYC))); // R8

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_o) |-> (hi_run == HW'(PULSE_CYC))); // R8
endmodule

bind sc_guarded_cfg sc_guarded_cfg_chk #(
  .PULSE_CYC (PULSE_CYC),
  .SWRST_BIT (SWRST_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .guard_open (guard_open),
  .err_flag   (err_flag),
  .dev_q      (dev_q),
  .clk_q      (clk_q),
  .srst_o     (srst_o)
);

// File: tb/tb_sc_guarded_cfg.sv
`timescale 1ns/1ps
module tb_sc_guarded_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        srst_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // requirement-level model
  logic [31:0] m_dev, m_clk;
  bit          m_open, m_err;
  int          m_cnt;
  logic [31:0] last_rd;

  always #4 clk = ~clk;

  sc_guarded_cfg dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .srst_o(srst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1 last_rd = bus_rdata;
    @(posedge clk);
    if (m_cnt > 0) m_cnt--;
    if (wr) begin
      if (a == 3'd1 || a == 3'd2) begin
        if (m_open) begin
          if (a == 3'd1) begin
            if (m_dev[31] && !d[31]) m_cnt = 4;
            m_dev = d;
          end else m_clk = d;
        end else m_err = 1;
      end
      if (a == 3'd4) m_err = 0;
      m_open = (a == 3'd0 && d == 32'hAA);
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R8 srst_o per cycle", {31'b0, srst_o}, {31'b0, (m_cnt > 0)});
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cyc(1'b0, a, 32'h0);
    v = last_rd;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(3'd0, v); chk({tag, " R2 key readback"}, v, {31'b0, m_open});
    rd(3'd1, v); chk({tag, " R3/R5 devcfg"}, v, m_dev);
    rd(3'd2, v); chk({tag, " R3/R5 clkdiv"}, v, m_clk);
    rd(3'd4, v); chk({tag, " R6 error bit"}, v, {31'b0, m_err});
    rd(3'd3, v); chk({tag, " R7 revision"}, v, 32'h5000_0000);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    int hi;
    pats[0] = 32'h1234_5678; pats[1] = 32'h0000_0000;
    pats[2] = 32'h7FFF_FFFF; pats[3] = 32'h00A5_5A00;
    m_dev = 0; m_clk = 0; m_open = 0; m_err = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 srst_o low", {31'b0, srst_o}, 32'h0);
    rd(3'd1, v); chk("R1 devcfg reset", v, 32'h0);
    rd(3'd2, v); chk("R1 clkdiv reset", v, 32'h0);
    rd(3'd0, v); chk("R1 guard shut", v, 32'h0);
    rd(3'd4, v); chk("R1 error clear", v, 32'h0);

    // sweep: pattern x target x the access between key and guarded write
    for (int p = 0; p < 4; p++) begin
      for (int t = 1; t <= 2; t++) begin
        for (int mid = 0; mid < 10; mid++) begin
          // mid 0: none; 1: no key at all; 2..9: write (2..9 -> offs 0..7) ; reads tested below
          if (mid != 1) cyc(1'b1, 3'd0, 32'hAA);
          if (mid >= 2) cyc(1'b1, 3'(mid - 2), (mid == 2) ? 32'h55 : 32'hAA);
          cyc(1'b1, 3'(t), pats[p] ^ {28'b0, 4'(mid)});
          check_all("sweep R4");
          cyc(1'b1, 3'd4, 32'h0); // R6 clear
          rd(3'd4, v); chk("R6 cleared by status write", v, 32'h0);
        end
        // R9: reads in between keep the guard open
        for (int ra = 0; ra < 8; ra++) begin
          cyc(1'b1, 3'd0, 32'hAA);
          rd(3'(ra), v);
          rd(3'd0, v); chk("R9 read keeps guard", v, 32'h1);
          cyc(1'b1, 3'(t), pats[p] + 32'(ra));
          rd(3'(t), v); chk("R9 write after reads lands", v, pats[p] + 32'(ra));
          rd(3'd0, v); chk("R4 guard shut after write", v, 32'h0);
        end
      end
    end

    // key values near 0xAA do not open the guard
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 3'd0, (k == 0) ? 32'hAB : (k == 1) ? 32'h1AA : (k == 2) ? 32'h2A : 32'hAA00);
      rd(3'd0, v); chk("R2 wrong key keeps shut", v, 32'h0);
      cyc(1'b1, 3'd2, 32'hDEAD_0000 + 32'(k));
      rd(3'd2, v); chk("R5 wrong key write ignored", v, m_clk);
    end
    // error sticky across unrelated accesses
    rd(3'd4, v); chk("R6 sticky", v, 32'h1);
    cyc(1'b1, 3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R7 id write ignored", v, 32'h5000_0000);
    rd(3'd4, v); chk("R6 still set after other write", v, 32'h1);
    cyc(1'b1, 3'd4, 32'h0);

    // unmapped
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R10 unmapped reads zero", v, 32'h0);
    end

    // R8 reset pulse: set then clear
    cyc(1'b1, 3'd0, 32'hAA); cyc(1'b1, 3'd1, 32'h8000_0001);
    chk("R8 setting bit gives no pulse", {31'b0, srst_o}, 32'h0);
    cyc(1'b1, 3'd0, 32'hAA); cyc(1'b1, 3'd1, 32'h0000_0001);
    hi = srst_o ? 1 : 0;
    chk("R8 pulse starts next cycle", {31'b0, srst_o}, 32'h1);
    for (int i = 0; i < 7; i++) begin
      cyc(1'b0, 3'd0, 32'h0);
      if (srst_o) hi++;
    end
    chk("R8 pulse length", 32'(hi), 32'd4);
    // clearing when already clear: no pulse
    cyc(1'b1, 3'd0, 32'hAA); cyc(1'b1, 3'd1, 32'h0);
    chk("R8 clear-on-clear no pulse", {31'b0, srst_o}, 32'h0);
    // locked clear: no pulse
    cyc(1'b1, 3'd0, 32'hAA); cyc(1'b1, 3'd1, 32'h8000_0000);
    cyc(1'b1, 3'd1, 32'h0);
    chk("R8 locked clear no pulse", {31'b0, srst_o}, 32'h0);
    rd(3'd1, v); chk("R5 locked clear ignored", v, 32'h8000_0000);
    repeat (6) cyc(1'b0, 3'd0, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule